// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the control register that an embedded flash array controller consults before it starts a program or erase pass. Software sets a per-block selection mask, chooses between programming and erasing, can aim the operation at the censorship bits instead of the normal array, and can ask for a running high-voltage operation to pause. The register enforces write interlocks that depend on the controller's live state. One input, `pgm_armed_i`, is high once a program/erase sequence has been armed. The other, `hv_active_i`, is high while high voltage is applied to the array.

The block's outputs are the blocks to program and the blocks to erase, the censor set and clear requests, and a lock line for the neighbouring configuration register. That lock line freezes the lock, interrupt-control, access, supervisor, data and protection fields of the neighbour. There is also a suspend acknowledge and an interrupt enable. A single 32-bit word is written through byte-lane strobes and read back in full.

Register layout:

| Bits | Field |
|------|-------|
| [7:0] | block mask, in byte lane 0 |
| 8 | erase select |
| 9 | censor select |
| 10 | suspend request |
| 11 | interrupt enable, held in byte lane 1 |
| [31:12] | reserved |

Top module: `pfc_ctl`

## Requirements
- R1: After reset every field reads 0. Reserved bits [31:12] of `rd_data` always read 0 and ignore writes.
- R2: With `pgm_armed_i` low, a write with `wr_be[0]` set loads `wr_data[7:0]` into the block mask at bits [7:0]. Bit M selects block M, and any combination may be loaded, including all eight blocks.
- R3: While `pgm_armed_i` is 1, writes leave the block mask, erase select (bit 8) and censor select (bit 9) unchanged.
- R4: Erase select 0 means program mode: `prog_blk_o` equals the mask and `erase_blk_o` is 0. Erase select 1 means erase mode: `erase_blk_o` equals the mask, so every selected block is erased together, and `prog_blk_o` is 0.
- R5: Interrupt enable (bit 11) ignores writes while `pgm_armed_i` is 1 and erase select is 0. In erase mode, or while unarmed, it follows writes with `wr_be[1]` set. Its value appears on `irq_en_o`.
- R6: With censor select 1, `censor_set_o` is 1 in program mode and `censor_clr_o` is 1 in erase mode. Both are 0 when censor select is 0.
- R7: `cfg_lock_o` equals the censor select bit.
- R8: The suspend request (bit 10) accepts writes with `wr_be[1]` set only while `hv_active_i` is 1. Without such a write it holds its value.
- R9: In any cycle where `hv_active_i` is 0, the suspend request is cleared at the next clock edge.
- R10: `susp_ack_o` is 1 exactly when the suspend request is 1 and `hv_active_i` is 1.
- R11: A byte lane whose `wr_be` bit is 0 is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane write enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back of the whole register |
| pgm_armed_i | input | 1 | Program/erase sequence armed |
| hv_active_i | input | 1 | High-voltage operation in progress |
| prog_blk_o | output | 8 | Blocks selected for programming |
| erase_blk_o | output | 8 | Blocks selected for erasing |
| censor_set_o | output | 1 | Operation sets the censor bits |
| censor_clr_o | output | 1 | Operation clears the censor bits |
| cfg_lock_o | output | 1 | Write lock for the neighbouring configuration fields |
| susp_ack_o | output | 1 | Suspend in effect |
| irq_en_o | output | 1 | Interrupt enable field |

## Verification
Every field is visible on `rd_data`, so a corrupted field shows in the first cycle after the write that caused it. A lock that fails to hold leaves a modified mask or mode bit one edge after the blocked write. That same change also shows on the routed block outputs or the censor lines in that cycle. A suspend bit that survives the end of high voltage shows on `rd_data[10]` one edge after `hv_active_i` falls. The suspend acknowledge is combinational, so a wrong acknowledge appears in the same cycle as the input change.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int REG_W    = 32;
  localparam int BE_W     = REG_W / 8;
  localparam int NUM_BLK  = 8;
  localparam int ERASE_B  = 8;
  localparam int CENS_B   = 9;
  localparam int SUSP_B   = 10;
  localparam int IRQ_B    = 11;
  localparam int USED_W   = 12;

  typedef struct packed {
    logic               irq_en;
    logic               susp;
    logic               cens;
    logic               erase;
    logic [NUM_BLK-1:0] blk;
  } pfc_state_t;

  // interrupt enable is frozen only when armed in program mode
  function automatic logic irq_wr_ok(logic armed, logic erase);
    return !armed || erase;
  endfunction

  function automatic logic [REG_W-1:0] pack_state(pfc_state_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[NUM_BLK-1:0] = s.blk;
    w[ERASE_B]     = s.erase;
    w[CENS_B]      = s.cens;
    w[SUSP_B]      = s.susp;
    w[IRQ_B]       = s.irq_en;
    return w;
  endfunction
endpackage

// File: rtl/pfc_lane_dec.sv
module pfc_lane_dec #(
  parameter int BE_W = 4
) (
  input  logic            wr_en,
  input  logic [BE_W-1:0] wr_be,
  output logic [BE_W-1:0] lane_wr
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lane_wr[i] = wr_en & wr_be[i];
  end
endmodule

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
  import pfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_we,
  input  logic               mode_we,
  input  logic               irq_we,
  input  logic [NUM_BLK-1:0] blk_d,
  input  logic               erase_d,
  input  logic               cens_d,
  input  logic               irq_d,
  output logic [NUM_BLK-1:0] blk_q,
  output logic               erase_q,
  output logic               cens_q,
  output logic               irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      erase_q <= 1'b0;
      cens_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (blk_we) blk_q <= blk_d;
      if (mode_we) begin
        erase_q <= erase_d;
        cens_q  <= cens_d;
      end
      if (irq_we) irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/pfc_susp_ctl.sv
module pfc_susp_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_active,
  input  logic susp_we,
  input  logic susp_d,
  output logic susp_q,
  output logic susp_ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         susp_q <= 1'b0;
    else if (!hv_active) susp_q <= 1'b0;
    else if (susp_we)   susp_q <= susp_d;
  end

  assign susp_ack = susp_q & hv_active;
endmodule

// File: rtl/pfc_ctl.sv
module pfc_ctl
  import pfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               pgm_armed_i,
  input  logic               hv_active_i,
  output logic [NUM_BLK-1:0] prog_blk_o,
  output logic [NUM_BLK-1:0] erase_blk_o,
  output logic               censor_set_o,
  output logic               censor_clr_o,
  output logic               cfg_lock_o,
  output logic               susp_ack_o,
  output logic               irq_en_o
);
  logic [BE_W-1:0] lane_wr;
  logic            blk_we, mode_we, irq_we, susp_we;
  pfc_state_t      st;

  pfc_lane_dec #(.BE_W(BE_W)) u_lane (
    .wr_en  (wr_en),
    .wr_be  (wr_be),
    .lane_wr(lane_wr)
  );

  // interlocks: arming freezes selection fields, voltage gates suspend
  assign blk_we  = lane_wr[0] & ~pgm_armed_i;
  assign mode_we = lane_wr[1] & ~pgm_armed_i;
  assign irq_we  = lane_wr[1] & irq_wr_ok(pgm_armed_i, st.erase);
  assign susp_we = lane_wr[1] & hv_active_i;

  pfc_cfg_regs u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .blk_we (blk_we),
    .mode_we(mode_we),
    .irq_we (irq_we),
    .blk_d  (wr_data[NUM_BLK-1:0]),
    .erase_d(wr_data[ERASE_B]),
    .cens_d (wr_data[CENS_B]),
    .irq_d  (wr_data[IRQ_B]),
    .blk_q  (st.blk),
    .erase_q(st.erase),
    .cens_q (st.cens),
    .irq_q  (st.irq_en)
  );

  pfc_susp_ctl u_susp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hv_active(hv_active_i),
    .susp_we  (susp_we),
    .susp_d   (wr_data[SUSP_B]),
    .susp_q   (st.susp),
    .susp_ack (susp_ack_o)
  );

  assign rd_data      = pack_state(st);
  assign prog_blk_o   = st.erase ? '0 : st.blk;
  assign erase_blk_o  = st.erase ? st.blk : '0;
  assign censor_set_o = st.cens & ~st.erase;
  assign censor_clr_o = st.cens & st.erase;
  assign cfg_lock_o   = st.cens;
  assign irq_en_o     = st.irq_en;
endmodule

// File: rtl/pfc_ctl_chk.sv
module pfc_ctl_chk
  import pfc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [BE_W-1:0]    wr_be,
  input logic [REG_W-1:0]   rd_data,
  input logic               pgm_armed_i,
  input logic               hv_active_i,
  input logic [NUM_BLK-1:0] prog_blk_o,
  input logic [NUM_BLK-1:0] erase_blk_o,
  input logic               censor_set_o,
  input logic               censor_clr_o,
  input logic               cfg_lock_o,
  input logic               susp_ack_o
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:USED_W] == '0);

  // R3
  armed_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_armed_i |=> $stable(rd_data[CENS_B:0]));

  // R4
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|prog_blk_o, |erase_blk_o}));

  // R5
  irq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_armed_i && !rd_data[ERASE_B]) |=> $stable(rd_data[IRQ_B]));

  // R6
  censor_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(censor_set_o && censor_clr_o));

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (censor_set_o || censor_clr_o) |-> cfg_lock_o);

  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_active_i && !(wr_en && wr_be[1])) |=> $stable(rd_data[SUSP_B]));

  // R9
  susp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_active_i |=> !rd_data[SUSP_B]);

  // R10
  susp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_ack_o |-> (hv_active_i && rd_data[SUSP_B]));
endmodule

bind pfc_ctl pfc_ctl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_be       (wr_be),
  .rd_data     (rd_data),
  .pgm_armed_i (pgm_armed_i),
  .hv_active_i (hv_active_i),
  .prog_blk_o  (prog_blk_o),
  .erase_blk_o (erase_blk_o),
  .censor_set_o(censor_set_o),
  .censor_clr_o(censor_clr_o),
  .cfg_lock_o  (cfg_lock_o),
  .susp_ack_o  (susp_ack_o)
);

// File: tb/pfc_ctl_tb.sv
module pfc_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        pgm_armed_i = 1'b0;
  logic        hv_active_i = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  prog_blk_o, erase_blk_o;
  logic        censor_set_o, censor_clr_o, cfg_lock_o, susp_ack_o, irq_en_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [7:0] m_blk;
  logic m_er, m_cen, m_sus, m_irq;

  always #2.5 clk = ~clk;

  pfc_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .pgm_armed_i(pgm_armed_i), .hv_active_i(hv_active_i),
    .prog_blk_o(prog_blk_o), .erase_blk_o(erase_blk_o),
    .censor_set_o(censor_set_o), .censor_clr_o(censor_clr_o),
    .cfg_lock_o(cfg_lock_o), .susp_ack_o(susp_ack_o), .irq_en_o(irq_en_o)
  );

  function automatic logic [31:0] exp_word();
    return {20'h0, m_irq, m_sus, m_cen, m_er, m_blk};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1/R2/R11 rd_data", rd_data, exp_word());
    chk("R4 prog_blk_o", {24'h0, prog_blk_o}, m_er ? 32'h0 : {24'h0, m_blk});
    chk("R4 erase_blk_o", {24'h0, erase_blk_o}, m_er ? {24'h0, m_blk} : 32'h0);
    chk("R6 censor_set_o", {31'h0, censor_set_o}, {31'h0, m_cen && !m_er});
    chk("R6 censor_clr_o", {31'h0, censor_clr_o}, {31'h0, m_cen && m_er});
    chk("R7 cfg_lock_o", {31'h0, cfg_lock_o}, {31'h0, m_cen});
    chk("R10 susp_ack_o", {31'h0, susp_ack_o}, {31'h0, m_sus && hv_active_i});
    chk("R5 irq_en_o", {31'h0, irq_en_o}, {31'h0, m_irq});
  endtask

  task automatic step(logic we, logic [3:0] be, logic [31:0] d, logic armed, logic hv);
    logic l0, l1;
    @(negedge clk);
    wr_en = we; wr_be = be; wr_data = d; pgm_armed_i = armed; hv_active_i = hv;
    l0 = we && be[0];
    l1 = we && be[1];
    // R5 (uses mode before the write)
    if (l1 && (armed ? m_er : 1'b1)) m_irq = d[11];
    // R8 / R9
    if (!hv) m_sus = 1'b0;
    else if (l1) m_sus = d[10];
    // R2 / R3
    if (!armed) begin
      if (l0) m_blk = d[7:0];
      if (l1) begin m_er = d[8]; m_cen = d[9]; end
    end
    @(posedge clk);
    #1;
    check_all();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    m_blk = '0; m_er = 0; m_cen = 0; m_sus = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all();                                  // R1 reset state
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all();

    // R2 R4: mask 11100100 erases blocks 2,5,6,7 together
    step(1, 4'b0011, 32'h0000_01E4, 0, 0);
    step(1, 4'b0011, 32'h0000_00FF, 0, 0);        // R2 all blocks, program
    // R3: armed blocks mask and mode
    step(1, 4'b0011, 32'h0000_0300, 1, 0);
    // R5: armed in program mode freezes interrupt enable
    step(1, 4'b0010, 32'h0000_0800, 1, 0);
    // R5: erase mode, armed, interrupt enable writable
    step(1, 4'b0010, 32'h0000_0100, 0, 0);
    step(1, 4'b0010, 32'h0000_0900, 1, 0);
    // R6 R7: censor set then clear
    step(1, 4'b0010, 32'h0000_0200, 0, 0);
    step(1, 4'b0010, 32'h0000_0300, 0, 0);
    // R1: reserved bits ignore writes
    step(1, 4'b1111, 32'hFFFF_F000, 0, 0);
    // R11: lane 1 only, mask untouched
    step(1, 4'b0010, 32'h0000_00AA, 0, 0);
    // R8: suspend ignored without high voltage
    step(1, 4'b0010, 32'h0000_0400, 0, 0);
    // R8 R10: suspend accepted and acknowledged
    step(1, 4'b0010, 32'h0000_0400, 1, 1);
    step(0, 4'b0000, 32'h0, 1, 1);
    // R9: voltage drops, suspend cleared
    step(0, 4'b0000, 32'h0, 1, 0);
    step(0, 4'b0000, 32'h0, 1, 1);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 4'($urandom), $urandom,
           ($urandom % 3) == 0, ($urandom % 3) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule